// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block forms the word returned on every read of a parallel NOR-style flash device. A separate command sequencer holds the active command code and the write-cycle index. This block looks at both and chooses what the read returns. It can return plain array contents, a status byte whose toggle bit flips on every poll, identification words, or a byte from a query table. The query table is an external ROM. The block drives the ROM's index and takes the byte back in the same cycle.

The block also tracks whether the device is in direct array mode or register mode. A write taken while the write-cycle index is zero moves it to register mode. Reads that stay idle in register mode are counted. After enough of them, direct array mode comes back on its own. When a read finds a command code the block does not know, it returns array data and sends an abort pulse to the sequencer, which then drops back to idle.

Top module: `flash_rdmux`

## Requirements
- R1: The register offset is address bits [7:0] shifted right according to `bus_width`. Code 0 means a 1-byte bus and gives no shift. Code 1 means a 2-byte bus and gives a shift of 1. Codes 2 and 3 mean a 4-byte bus and give a shift of 2.
- R2: When the command code is 0x00 (idle) or 0x80 (erase setup), a read returns `mem_data`.
- R3: When the command code is 0x90 (identify), offsets 0 and 1 return ID words 0 and 1, and offset 2 returns 0. Each ID word is zero-extended to the data width.
- R4: When the command code is 0x90, offset 0x0E returns ID word 2 and offset 0x0F returns ID word 3. If the selected word's low byte is 0xFF, that offset returns `mem_data` instead. Every other offset returns `mem_data`.
- R5: When the command code is 0xA0, 0x10 or 0x30 (program or erase busy), a read returns a status byte. Bit 7 of that byte is `busy_dq7`, bit 6 is the toggle bit, and all other bits are 0. The toggle bit resets to 0 and inverts after each such read. No other read changes it.
- R6: When the command code is 0x98 (query), a read returns `qry_byte` for the offset driven on `qry_idx`. Offsets at or beyond the table depth (0x4D) return 0.
- R7: `array_mode` is 1 after reset. A write taken while `wr_cycle` is 0 clears it. Any write resets the idle-read count. While `array_mode` is 0 and `wr_cycle` is 0, each read adds one to the count. On the 43rd such read, `array_mode` returns to 1 (the count has then exceeded 42). Reads taken while `wr_cycle` is not 0 are not counted.
- R8: A read under any command code not named in R2, R3, R5 or R6 returns `mem_data`. It also raises `cmd_abort` for one cycle, together with `rd_valid`.
- R9: `rd_data`, `rd_valid` and `cmd_abort` are registered. `rd_valid` is high exactly one cycle after a cycle with `rd_en` high. After reset, `rd_valid`, `cmd_abort` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| bus_width | input | 2 | Bus width code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| cmd_state | input | 8 | Active command code from the sequencer |
| wr_cycle | input | 3 | Write-cycle index from the sequencer |
| wr_seen | input | 1 | A device write is taken this cycle |
| busy_dq7 | input | 1 | Status bit 7 supplied by the sequencer |
| mem_data | input | DATA_W | Array word at `rd_addr` |
| qry_idx | output | 8 | Query ROM index (current offset) |
| qry_byte | input | 8 | Query ROM byte at `qry_idx` |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | `rd_data` is valid |
| cmd_abort | output | 1 | Unknown command seen on a read |
| array_mode | output | 1 | Device is in direct array mode |

## Verification
The bench mixes randomized reads with directed cases. The random reads draw the command code from all the legal codes and some unknown ones, and they draw the address and bus width at random. Each read is compared with a model of the requirements, so wrong offset scaling shows up as an ID or query mismatch, and wrong decoding shows up as array data where a register byte was expected. Directed cases cover three areas. The first covers ID offsets 0x0E and 0x0F, with and without the 0xFF fallback, and query offsets just inside and beyond the table depth. The second polls status repeatedly to show the toggle bit alternating while array reads leave it alone. The third counts idle reads up to the 42/43 boundary, with interleaved non-zero write-cycle reads and a clearing write in between.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;
  localparam logic [7:0] CMD_IDLE   = 8'h00;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_CERASE = 8'h10;
  localparam logic [7:0] CMD_SERASE = 8'h30;
  localparam logic [7:0] CMD_QUERY  = 8'h98;

  typedef enum logic [2:0] {
    SRC_ARRAY, SRC_ID, SRC_ZERO, SRC_STATUS, SRC_QUERY
  } rd_src_e;
endpackage

// File: rtl/rdmux_offset.sv
module rdmux_offset #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bus_width,
  output logic [7:0]        offset
);
  logic [7:0] low_byte;
  assign low_byte = addr[7:0];

  always_comb begin
    if (bus_width[1])      offset = {2'b00, low_byte[7:2]};
    else if (bus_width[0]) offset = {1'b0, low_byte[7:1]};
    else                   offset = low_byte;
  end
endmodule

// File: rtl/rdmux_mode_tracker.sv
module rdmux_mode_tracker #(
  parameter int IDLE_LIMIT = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_seen,
  input  logic cycle_zero,
  output logic array_mode
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             counting;

  assign counting = rd_en && !array_mode && cycle_zero;
  assign cnt_inc  = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      array_mode <= 1'b1;
    end else if (wr_seen) begin
      cnt_q <= '0;
      if (cycle_zero) array_mode <= 1'b0;
    end else if (counting) begin
      cnt_q <= cnt_inc;
      if (int'(cnt_inc) > IDLE_LIMIT) array_mode <= 1'b1;
    end
  end

  assert_write_leaves_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_seen && cycle_zero) |=> !array_mode);
  assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
    wr_seen |=> (cnt_q == '0));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= IDLE_LIMIT + 1);
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
  import flash_rdmux_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          QRY_DEPTH  = 77,
  parameter int          IDLE_LIMIT = 42,
  parameter logic [15:0] ID_W0      = 16'h0001,
  parameter logic [15:0] ID_W1      = 16'h227E,
  parameter logic [15:0] ID_W2      = 16'h2221,
  parameter logic [15:0] ID_W3      = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        bus_width,
  input  logic [7:0]        cmd_state,
  input  logic [2:0]        wr_cycle,
  input  logic              wr_seen,
  input  logic              busy_dq7,
  input  logic [DATA_W-1:0] mem_data,
  output logic [7:0]        qry_idx,
  input  logic [7:0]        qry_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cmd_abort,
  output logic              array_mode
);
  logic [7:0]        offset;
  rd_src_e           src;
  logic [15:0]       id_sel;
  logic              unknown;
  logic              tog_q;
  logic [DATA_W-1:0] next_data;

  rdmux_offset #(.ADDR_W(ADDR_W)) u_offset (
    .addr(rd_addr), .bus_width(bus_width), .offset(offset)
  );

  rdmux_mode_tracker #(.IDLE_LIMIT(IDLE_LIMIT)) u_mode (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_seen(wr_seen),
    .cycle_zero(wr_cycle == 3'd0), .array_mode(array_mode)
  );

  assign qry_idx = offset;

  always_comb begin
    src     = SRC_ARRAY;
    id_sel  = ID_W0;
    unknown = 1'b0;
    case (cmd_state)
      CMD_IDLE, CMD_ESETUP: src = SRC_ARRAY;
      CMD_IDENT: begin
        case (offset)
          8'h00: begin src = SRC_ID; id_sel = ID_W0; end
          8'h01: begin src = SRC_ID; id_sel = ID_W1; end
          8'h02: src = SRC_ZERO;
          8'h0E: begin
            id_sel = ID_W2;
            src    = (ID_W2[7:0] == 8'hFF) ? SRC_ARRAY : SRC_ID;
          end
          8'h0F: begin
            id_sel = ID_W3;
            src    = (ID_W3[7:0] == 8'hFF) ? SRC_ARRAY : SRC_ID;
          end
          default: src = SRC_ARRAY;
        endcase
      end
      CMD_PROG, CMD_CERASE, CMD_SERASE: src = SRC_STATUS;
      CMD_QUERY: src = (int'(offset) < QRY_DEPTH) ? SRC_QUERY : SRC_ZERO;
      default: begin src = SRC_ARRAY; unknown = 1'b1; end
    endcase
  end

  always_comb begin
    case (src)
      SRC_ID:     next_data = DATA_W'(id_sel);
      SRC_ZERO:   next_data = '0;
      SRC_STATUS: next_data = DATA_W'({busy_dq7, tog_q, 6'b0});
      SRC_QUERY:  next_data = DATA_W'(qry_byte);
      default:    next_data = mem_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      cmd_abort <= 1'b0;
      tog_q     <= 1'b0;
    end else begin
      rd_valid  <= rd_en;
      cmd_abort <= rd_en && unknown;
      if (rd_en) rd_data <= next_data;
      if (rd_en && src == SRC_STATUS) tog_q <= ~tog_q;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_tog_flips_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && src == SRC_STATUS) |=> (tog_q != $past(tog_q)));
  assert_tog_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && src == SRC_STATUS) |=> $stable(tog_q));
  assert_abort_valid_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |-> rd_valid);
  assert_query_beyond_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_state == CMD_QUERY && int'(offset) >= QRY_DEPTH)
      |=> (rd_data == '0));
endmodule

// File: tb/flash_rdmux_test.sv
module flash_rdmux_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd_en, wr_seen, busy_dq7;
  logic [15:0] rd_addr;
  logic [1:0]  bus_width;
  logic [7:0]  cmd_state;
  logic [2:0]  wr_cycle;
  logic [31:0] mem_data;
  logic [7:0]  qry_idx, qry_byte;
  logic [31:0] rd_data;
  logic        rd_valid, cmd_abort, array_mode;

  int n_run = 0, n_fail = 0;
  bit m_tog, m_arr;
  int m_cnt;

  always #10 clk = ~clk;

  flash_rdmux uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .bus_width(bus_width), .cmd_state(cmd_state), .wr_cycle(wr_cycle),
    .wr_seen(wr_seen), .busy_dq7(busy_dq7), .mem_data(mem_data),
    .qry_idx(qry_idx), .qry_byte(qry_byte), .rd_data(rd_data),
    .rd_valid(rd_valid), .cmd_abort(cmd_abort), .array_mode(array_mode)
  );

  function automatic logic [31:0] mem_of(logic [15:0] a);
    return 32'hA5C30000 ^ ({16'h0, a} * 32'h9E37);
  endfunction
  assign mem_data = mem_of(rd_addr);
  assign qry_byte = qry_idx ^ 8'h5A;

  function automatic logic [7:0] off_of(logic [15:0] a, logic [1:0] w);
    return w[1] ? {2'b0, a[7:2]} : (w[0] ? {1'b0, a[7:1]} : a[7:0]);
  endfunction

  function automatic bit is_known(logic [7:0] c);
    return c == 8'h00 || c == 8'h80 || c == 8'h90 || c == 8'hA0 ||
           c == 8'h10 || c == 8'h30 || c == 8'h98;
  endfunction

  function automatic logic [31:0] expect_of(logic [7:0] c, logic [15:0] a,
                                            logic [1:0] w, bit d7, bit tg);
    logic [7:0] o;
    o = off_of(a, w);
    case (c)
      8'h90: begin
        if (o == 8'h00) return 32'h0001;
        if (o == 8'h01) return 32'h227E;
        if (o == 8'h02) return 32'h0;
        if (o == 8'h0E) return 32'h2221;
        return mem_of(a);
      end
      8'hA0, 8'h10, 8'h30: return {24'h0, d7, tg, 6'b0};
      8'h98: return (o < 8'h4D) ? {24'h0, o ^ 8'h5A} : 32'h0;
      default: return mem_of(a);
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [7:0] c, logic [15:0] a, logic [1:0] w,
                         logic [2:0] wc, bit d7, string req);
    logic [31:0] e;
    e = expect_of(c, a, w, d7, m_tog);
    @(negedge clk);
    rd_en = 1'b1; cmd_state = c; rd_addr = a; bus_width = w;
    wr_cycle = wc; busy_dq7 = d7;
    if (c == 8'hA0 || c == 8'h10 || c == 8'h30) m_tog = !m_tog;
    if (!m_arr && wc == 3'd0) begin
      m_cnt++;
      if (m_cnt > 42) m_arr = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " data"}, rd_data, e);
    chk("R9 valid", {31'h0, rd_valid}, 32'h1);
    chk("R8 abort", {31'h0, cmd_abort}, {31'h0, !is_known(c)});
    chk("R7 mode", {31'h0, array_mode}, {31'h0, m_arr});
  endtask

  task automatic do_write(logic [2:0] wc);
    @(negedge clk);
    wr_seen = 1'b1; wr_cycle = wc;
    m_cnt = 0;
    if (wc == 3'd0) m_arr = 1'b0;
    @(negedge clk);
    wr_seen = 1'b0;
    chk("R7 write mode", {31'h0, array_mode}, {31'h0, m_arr});
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] cmds [10];
    cmds = '{8'h00, 8'h80, 8'h90, 8'hA0, 8'h10, 8'h30, 8'h98, 8'h55, 8'hF0, 8'h91};
    void'($urandom(32'd1234));
    rst = 1'b1; rd_en = 0; wr_seen = 0; busy_dq7 = 0; rd_addr = 0;
    bus_width = 0; cmd_state = 0; wr_cycle = 0;
    m_tog = 0; m_arr = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset valid", {31'h0, rd_valid}, 32'h0);
    chk("R9 reset data", rd_data, 32'h0);
    chk("R9 reset abort", {31'h0, cmd_abort}, 32'h0);
    chk("R7 reset mode", {31'h0, array_mode}, 32'h1);
    @(negedge clk);
    chk("R9 idle valid", {31'h0, rd_valid}, 32'h0);

    // R2 array reads
    do_read(8'h00, 16'h1234, 2'd0, 0, 0, "R2");
    do_read(8'h80, 16'h0456, 2'd1, 0, 0, "R2");
    // R3 / R1 ID offsets under scaling
    do_read(8'h90, 16'h0000, 2'd0, 0, 0, "R3");
    do_read(8'h90, 16'h0002, 2'd1, 0, 0, "R3 R1");
    do_read(8'h90, 16'h0008, 2'd2, 0, 0, "R3 R1");
    do_read(8'h90, 16'h0302, 2'd0, 0, 0, "R3");
    // R4 extended ID and fallback
    do_read(8'h90, 16'h001C, 2'd1, 0, 0, "R4 word2");
    do_read(8'h90, 16'h003C, 2'd3, 0, 0, "R4 fallback");
    do_read(8'h90, 16'h0005, 2'd0, 0, 0, "R4 other");
    // R5 status toggle
    do_read(8'hA0, 16'h0000, 2'd0, 0, 1, "R5");
    do_read(8'h30, 16'h0000, 2'd0, 0, 1, "R5");
    do_read(8'h00, 16'h0010, 2'd0, 0, 0, "R5 untouched");
    do_read(8'h10, 16'h0000, 2'd0, 0, 0, "R5");
    // R6 query boundary
    do_read(8'h98, 16'h0010, 2'd0, 0, 0, "R6");
    do_read(8'h98, 16'h004C, 2'd0, 0, 0, "R6 last");
    do_read(8'h98, 16'h004D, 2'd0, 0, 0, "R6 beyond");
    do_read(8'h98, 16'h009A, 2'd1, 0, 0, "R6 beyond R1");
    // R8 unknown
    do_read(8'h55, 16'h0777, 2'd0, 0, 0, "R8");

    // R7 idle read counting
    do_write(3'd0);
    for (int i = 0; i < 20; i++) do_read(8'h00, 16'(i), 2'd0, 0, 0, "R7");
    do_read(8'h00, 16'h0, 2'd0, 3'd2, 0, "R7 nonzero cycle");
    do_write(3'd1);
    for (int i = 0; i < 42; i++) do_read(8'h90, 16'(i), 2'd0, 0, 0, "R7");
    chk("R7 at 42", {31'h0, array_mode}, 32'h0);
    do_read(8'h00, 16'h0099, 2'd0, 0, 0, "R7 43rd");
    chk("R7 restored", {31'h0, array_mode}, 32'h1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) do_write(3'($urandom_range(0, 3)));
      do_read(cmds[$urandom_range(0, 9)], 16'($urandom()),
              2'($urandom_range(0, 3)),
              ($urandom_range(0, 3) == 0) ? 3'd1 : 3'd0,
              1'($urandom_range(0, 1)), "R1 R2 R3 R4 R5 R6 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule